// File: doc/BRIEF.md
# Programmable Delay and Pulse Shaper

This block aligns a group of trigger channels in time before they reach a coincidence stage. Each channel arrives as a 4-bit word per clock cycle. Each bit is one 1 ns time slot, and bit 0 is the earliest slot of the cycle. Cable and port differences leave the channels skewed. The block removes that skew by delaying every channel by its own programmable amount, set in whole nanoseconds. It then replaces each delayed hit with a clean pulse of programmable length, set in 4 ns units. The downstream logic therefore sees pulses that are aligned and of known length.

Every channel keeps a circular history of its incoming words in an inferred RAM. A channel's delay value is split in two parts:
- The upper part selects how many whole cycles back to read.
- The lower two bits select a shift across two neighbouring stored words.

A slot-serial shaper follows. It detects 0-to-1 transitions, including transitions that cross a word boundary, and runs a slot counter that a new transition reloads. Software-style writes through a small write-only port set the delay and width of each channel. Out-of-range values are clamped.

Top module: `pulse_delay_shaper`

## Requirements
- R1: While `rst_n` is low, `dout` is all zero. After reset, every channel has a delay of 12 ns and a width code of 1 (4 ns).
- R2: Input word sampled at clock edge m holds slots 4m..4m+3, with bit j being slot 4m+j. Delayed slot k of a channel equals input slot k−D of that channel, where D is the channel's delay in ns.
- R3: Any delay from 12 to 128 ns is honoured in 1 ns steps, including values that are not multiples of 4.
- R4: A delay write (`cfg_sel`=0, value in ns) below 12 is stored as 12, and one above 128 is stored as 128.
- R5: A delayed slot at 1 whose preceding delayed slot was 0 (across word boundaries too) starts a pulse of exactly 4·W slots, where W is the width code. The pulse length does not depend on how long the input stays high. `dout` after edge n+1 carries the shaped slots of the delayed word formed at edge n.
- R6: A width write (`cfg_sel`=1, value in 4 ns units) of 0 is stored as 1, and one above 16 is stored as 16.
- R7: A new rising transition during an active pulse restarts the count, so the pulse ends 4·W slots after the latest transition.
- R8: A configuration write at an edge takes effect from the next edge. It leaves the stored history intact, so a changed delay immediately reads the old data at the new offset. Without a write, the settings hold.
- R9: Slots older than the first word written since reset read as 0, whatever the RAM held before.
- R10: Channels are independent: each has its own history, delay, width and shaper state, and `cfg_ch` selects which channel a write targets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cycle clock, one cycle per 4 slots |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | N_CH*4 | Slot words, channel c in bits 4c+3..4c |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_ch | input | CH_W | Channel addressed by the write |
| cfg_sel | input | 1 | 0: delay in ns, 1: width in 4 ns units |
| cfg_val | input | 8 | Value written |
| dout | output | N_CH*4 | Delayed and reshaped slot words, same layout as din |

## Verification
The assertions check four properties on every cycle:
- Every stored delay and width lies within its clamp range.
- Settings do not move without a write.
- Every rising transition in a delayed word yields a non-zero output word on the next cycle.
- No output slot is ever high unless the delayed word or a pending pulse count justified it.

Only the bench's slot-level reference model can show the rest:
- exact 1 ns placement for each delay value;
- exact pulse lengths;
- retrigger extension;
- delay changes that reuse stored history;
- zero-masking of stale RAM contents after a second reset.

// File: rtl/pds_pkg.sv
package pds_pkg;
  localparam int SLOTS   = 4;
  localparam int FINE_W  = $clog2(SLOTS);
  localparam int DLY_MIN = 12;
  localparam int DLY_MAX = 128;
  localparam int DLY_W   = $clog2(DLY_MAX + 1);
  localparam int WID_MAX = 16;
  localparam int WCODE_W = $clog2(WID_MAX + 1);
  localparam int CNT_W   = $clog2(WID_MAX * SLOTS + 1);
  localparam int MAX_AGE = DLY_MAX / SLOTS + 1;
  localparam int FILL_W  = $clog2(MAX_AGE + 1);

  typedef logic [SLOTS-1:0] slot_t;

  typedef struct packed {
    slot_t            pulse;
    logic [CNT_W-1:0] rem;
    logic             last;
  } shape_t;

  function automatic logic [DLY_W-1:0] clamp_delay(input logic [DLY_W-1:0] v);
    if (v < DLY_W'(DLY_MIN)) return DLY_W'(DLY_MIN);
    if (v > DLY_W'(DLY_MAX)) return DLY_W'(DLY_MAX);
    return v;
  endfunction

  function automatic logic [WCODE_W-1:0] clamp_width(input logic [DLY_W-1:0] v);
    if (v == '0) return WCODE_W'(1);
    if (v > DLY_W'(WID_MAX)) return WCODE_W'(WID_MAX);
    return v[WCODE_W-1:0];
  endfunction

  // bit i of {newer, older} is older-word slot i; pick slots shifted by fine
  function automatic slot_t fine_align(input slot_t newer, input slot_t older,
                                       input logic [FINE_W-1:0] fine);
    logic [2*SLOTS-1:0] cat;
    logic [2*SLOTS-1:0] sh;
    cat = {newer, older};
    sh  = cat >> (SLOTS - int'(fine));
    return sh[SLOTS-1:0];
  endfunction

  // walk the slots in time order; a rising slot reloads the counter
  function automatic shape_t shape_word(input slot_t d, input logic prev,
                                        input logic [CNT_W-1:0] rem,
                                        input logic [WCODE_W-1:0] wcode);
    shape_t r;
    logic [CNT_W-1:0] c;
    logic p;
    c = rem;
    p = prev;
    r = '0;
    for (int j = 0; j < SLOTS; j++) begin
      if (d[j] && !p) c = CNT_W'(wcode) * CNT_W'(SLOTS);
      r.pulse[j] = (c != '0);
      if (c != '0) c = c - CNT_W'(1);
      p = d[j];
    end
    r.rem  = c;
    r.last = p;
    return r;
  endfunction
endpackage

// File: rtl/pds_cfg.sv
module pds_cfg import pds_pkg::*; #(
  parameter int N_CH = 4,
  parameter int CH_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_wr,
  input  logic [CH_W-1:0]         cfg_ch,
  input  logic                    cfg_sel,
  input  logic [DLY_W-1:0]        cfg_val,
  output logic [N_CH*DLY_W-1:0]   dly_cfg,
  output logic [N_CH*WCODE_W-1:0] wid_cfg
);
  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic hit;
    assign hit = cfg_wr && (cfg_ch == CH_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dly_cfg[i*DLY_W +: DLY_W]     <= DLY_W'(DLY_MIN);
        wid_cfg[i*WCODE_W +: WCODE_W] <= WCODE_W'(1);
      end else if (hit) begin
        if (!cfg_sel) dly_cfg[i*DLY_W +: DLY_W]     <= clamp_delay(cfg_val);
        else          wid_cfg[i*WCODE_W +: WCODE_W] <= clamp_width(cfg_val);
      end
    end
  end
endmodule

// File: rtl/pds_delay_lane.sv
module pds_delay_lane import pds_pkg::*; #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_t             din,
  input  logic [AW-1:0]     wr_addr,
  input  logic [FILL_W-1:0] fill,
  input  logic [DLY_W-1:0]  dly_ns,
  output slot_t             dly_word
);
  localparam int CW = DLY_W - FINE_W;

  slot_t mem [DEPTH];

  logic [CW-1:0]     coarse;
  logic [FINE_W-1:0] fine;
  logic [AW-1:0]     a_new, a_old;
  logic              new_ok, old_ok;
  slot_t             w_new, w_old;

  always_ff @(posedge clk) mem[wr_addr] <= din;

  always_comb begin
    coarse = dly_ns[DLY_W-1:FINE_W];
    fine   = dly_ns[FINE_W-1:0];
    a_new  = wr_addr - AW'(coarse);
    a_old  = a_new - AW'(1);
    new_ok = FILL_W'(coarse) <= fill;
    old_ok = (FILL_W'(coarse) + FILL_W'(1)) <= fill;
    w_new  = new_ok ? mem[a_new] : '0;
    w_old  = old_ok ? mem[a_old] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly_word <= '0;
    else        dly_word <= fine_align(w_new, w_old, fine);
  end
endmodule

// File: rtl/pds_shaper.sv
module pds_shaper import pds_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  slot_t              dly_word,
  input  logic [WCODE_W-1:0] wcode,
  output slot_t              pulse,
  output logic               busy,
  output logic               rise
);
  logic [CNT_W-1:0] rem_q;
  logic             last_q;
  shape_t           res;

  assign res  = shape_word(dly_word, last_q, rem_q, wcode);
  assign rise = (dly_word & ~{dly_word[SLOTS-2:0], last_q}) != '0;
  assign busy = rem_q != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse  <= '0;
      rem_q  <= '0;
      last_q <= 1'b0;
    end else begin
      pulse  <= res.pulse;
      rem_q  <= res.rem;
      last_q <= res.last;
    end
  end
endmodule

// File: rtl/pulse_delay_shaper.sv
module pulse_delay_shaper import pds_pkg::*; #(
  parameter int N_CH  = 4,
  parameter int DEPTH = 512,
  parameter int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_CH*SLOTS-1:0] din,
  input  logic                  cfg_wr,
  input  logic [CH_W-1:0]       cfg_ch,
  input  logic                  cfg_sel,
  input  logic [DLY_W-1:0]      cfg_val,
  output logic [N_CH*SLOTS-1:0] dout
);
  localparam int AW = $clog2(DEPTH);

  logic [AW-1:0]              wr_addr;
  logic [FILL_W-1:0]          fill;
  logic [N_CH*DLY_W-1:0]      dly_cfg_all;
  logic [N_CH*WCODE_W-1:0]    wid_cfg_all;
  logic [N_CH*SLOTS-1:0]      dly_all;
  logic [N_CH-1:0]            rise_all;
  logic [N_CH-1:0]            busy_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr <= '0;
      fill    <= '0;
    end else begin
      wr_addr <= wr_addr + AW'(1);
      if (fill != FILL_W'(MAX_AGE)) fill <= fill + FILL_W'(1);
    end
  end

  pds_cfg #(.N_CH(N_CH), .CH_W(CH_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ch(cfg_ch),
    .cfg_sel(cfg_sel), .cfg_val(cfg_val),
    .dly_cfg(dly_cfg_all), .wid_cfg(wid_cfg_all)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_lane
    pds_delay_lane #(.DEPTH(DEPTH), .AW(AW)) u_dly (
      .clk(clk), .rst_n(rst_n),
      .din(din[i*SLOTS +: SLOTS]),
      .wr_addr(wr_addr), .fill(fill),
      .dly_ns(dly_cfg_all[i*DLY_W +: DLY_W]),
      .dly_word(dly_all[i*SLOTS +: SLOTS])
    );
    pds_shaper u_shp (
      .clk(clk), .rst_n(rst_n),
      .dly_word(dly_all[i*SLOTS +: SLOTS]),
      .wcode(wid_cfg_all[i*WCODE_W +: WCODE_W]),
      .pulse(dout[i*SLOTS +: SLOTS]),
      .busy(busy_all[i]),
      .rise(rise_all[i])
    );
  end
endmodule

// File: rtl/pds_checker.sv
module pds_checker import pds_pkg::*; #(
  parameter int N_CH = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_wr,
  input logic [N_CH*DLY_W-1:0]   dly_cfg,
  input logic [N_CH*WCODE_W-1:0] wid_cfg,
  input logic [N_CH*SLOTS-1:0]   dly_all,
  input logic [N_CH-1:0]         rise_all,
  input logic [N_CH-1:0]         busy_all,
  input logic [N_CH*SLOTS-1:0]   dout
);
  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ($stable(dly_cfg) && $stable(wid_cfg)));

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    // R4
    dly_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_cfg[i*DLY_W +: DLY_W] >= DLY_W'(DLY_MIN)) &&
      (dly_cfg[i*DLY_W +: DLY_W] <= DLY_W'(DLY_MAX)));
    // R6
    wid_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wid_cfg[i*WCODE_W +: WCODE_W] >= WCODE_W'(1)) &&
      (wid_cfg[i*WCODE_W +: WCODE_W] <= WCODE_W'(WID_MAX)));
    // R5
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_all[i] |=> (dout[i*SLOTS +: SLOTS] != '0));
    // R7
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dout[i*SLOTS +: SLOTS] != '0) |->
        $past((dly_all[i*SLOTS +: SLOTS] != '0) || busy_all[i]));
  end
endmodule

bind pulse_delay_shaper pds_checker #(.N_CH(N_CH)) u_pds_checker (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
  .dly_cfg(dly_cfg_all), .wid_cfg(wid_cfg_all),
  .dly_all(dly_all), .rise_all(rise_all), .busy_all(busy_all),
  .dout(dout)
);

// File: tb/pulse_delay_shaper_bench.sv
`timescale 1ns/1ps
module pulse_delay_shaper_bench;
  localparam int NC = 4;
  localparam int CW = 2;
  localparam int HM = 1024;
  localparam int NONE = -1000000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NC*4-1:0] din = '0;
  logic            cfg_wr = 1'b0;
  logic [CW-1:0]   cfg_ch = '0;
  logic            cfg_sel = 1'b0;
  logic [7:0]      cfg_val = '0;
  logic [NC*4-1:0] dout;

  always #5 clk = ~clk;

  pulse_delay_shaper #(.N_CH(NC), .DEPTH(512)) u_pulse_delay_shaper (
    .clk(clk), .rst_n(rst_n), .din(din), .cfg_wr(cfg_wr), .cfg_ch(cfg_ch),
    .cfg_sel(cfg_sel), .cfg_val(cfg_val), .dout(dout)
  );

  int    checks = 0;
  int    fails = 0;
  string tag = "R1";

  // slot-level reference state
  bit       hist [NC][HM];
  int       n;
  int       mdly [NC];
  int       mwid [NC];
  bit [3:0] pend [NC];
  bit       prevb [NC];
  int       lrise [NC];
  int       span [NC];
  bit [3:0] expo [NC];
  bit       lvl [NC];
  logic [31:0] rs = 32'h1234_5678;
  int       mode = 1;

  function automatic int bclamp_d(int v);
    return (v < 12) ? 12 : ((v > 128) ? 128 : v);
  endfunction

  function automatic int bclamp_w(int v);
    return (v < 1) ? 1 : ((v > 16) ? 16 : v);
  endfunction

  function automatic void model_reset();
    n = 0;
    for (int c = 0; c < NC; c++) begin
      mdly[c] = 12; mwid[c] = 1; pend[c] = '0; prevb[c] = 1'b0;
      lrise[c] = NONE; span[c] = 0; expo[c] = '0;
    end
  endfunction

  function automatic void rng();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
  endfunction

  function automatic bit gen(int c);
    rng();
    case (mode)
      0: return 1'b0;
      1: return rs[3:0] == 4'h0;
      2: return rs[0];
      default: begin
        if (rs[4:0] == 5'h0) lvl[c] = ~lvl[c];
        return lvl[c];
      end
    endcase
  endfunction

  function automatic void model_step();
    for (int c = 0; c < NC; c++) begin
      bit [3:0] nw;
      for (int j = 0; j < 4; j++) begin
        int s;
        s = 4 * (n - 1) + j;
        if (pend[c][j] && !prevb[c]) begin
          lrise[c] = s;
          span[c]  = 4 * mwid[c];
        end
        expo[c][j] = (s - lrise[c]) < span[c];
        prevb[c] = pend[c][j];
      end
      for (int j = 0; j < 4; j++) begin
        int src;
        src = 4 * n + j - mdly[c];
        nw[j] = (src >= 0) ? hist[c][src % HM] : 1'b0;
      end
      pend[c] = nw;
      for (int j = 0; j < 4; j++) hist[c][(4 * n + j) % HM] = din[c*4 + j];
    end
    if (cfg_wr) begin
      if (!cfg_sel) mdly[cfg_ch] = bclamp_d(int'(cfg_val));
      else          mwid[cfg_ch] = bclamp_w(int'(cfg_val));
    end
    n++;
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    for (int c = 0; c < NC; c++)
      for (int j = 0; j < 4; j++) din[c*4 + j] = gen(c);
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    if (!rst_n) chk(dout == '0, "R1 dout during reset", int'(dout), 0);
    else
      for (int c = 0; c < NC; c++)
        chk(dout[c*4 +: 4] == expo[c], $sformatf("ch%0d word%0d", c, n - 1),
            int'(dout[c*4 +: 4]), int'(expo[c]));
  endtask

  task automatic setc(int c, bit sel, int v);
    cfg_wr = 1'b1; cfg_ch = CW'(c); cfg_sel = sel; cfg_val = 8'(v);
    tick();
    cfg_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) lvl[c] = 1'b0;
    // R1: outputs stay zero while reset is held, even with busy inputs
    tag = "R1"; mode = 2;
    repeat (4) tick();
    rst_n = 1'b1; model_reset();
    // R1 default settings, R9 unwritten history reads as zero
    tag = "R1 R9"; mode = 1;
    repeat (40) tick();
    // R2 R3 R10: per-channel delays off the 4 ns grid, distinct widths
    tag = "R8";
    setc(0, 0, 13); setc(1, 0, 14); setc(2, 0, 51); setc(3, 0, 127);
    setc(0, 1, 2);  setc(1, 1, 1);  setc(2, 1, 3);  setc(3, 1, 4);
    tag = "R2 R3 R10";
    repeat (300) tick();
    // R4: out-of-range delays clamp
    tag = "R4";
    setc(0, 0, 0); setc(1, 0, 200); setc(2, 0, 3); setc(3, 0, 128);
    repeat (200) tick();
    // R6 R5: width clamp, long input pulses reshaped to fixed length
    tag = "R6 R5"; mode = 3;
    setc(0, 1, 0); setc(1, 1, 40); setc(2, 1, 16); setc(3, 1, 7);
    repeat (300) tick();
    // R7: dense edges retrigger running pulses
    tag = "R7"; mode = 2;
    repeat (200) tick();
    // R8: delay changes on the fly reuse stored history
    tag = "R8"; mode = 1;
    for (int k = 0; k < 30; k++) begin
      setc(k % NC, 0, 12 + (k * 37) % 117);
      repeat (8) tick();
    end
    // R9: second reset, stale RAM must not leak through long delays
    tag = "R1"; mode = 2;
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1; model_reset();
    tag = "R9"; mode = 1;
    setc(0, 0, 128); setc(1, 0, 101); setc(2, 0, 77); setc(3, 0, 12);
    repeat (100) tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule